// File: doc/BRIEF.md
# Loading-Arm Configuration Sequencer

This block steers a configuration arm across a rectangular grid of logic blocks that has spare rows and columns built in. The arm is a path of grid positions held on a stack. Only the position at the tip of that path is ever acted upon. The block at the tip is first handed to an external tester. If it passes, it is handed to an external configurator. If it fails, it is recorded as faulty and is never configured. The sequencer keeps a map of faulty blocks and a map of visited blocks. It grows the path into a fresh neighbour whenever it can, and it pulls the path back by one position whenever it cannot.

A run starts with a one-cycle `start` pulse, which also gives the number of blocks that must be configured. The run ends in one of two ways. `done` is raised once that many blocks have been configured. `fail` is raised when the arm has to pull back but only its starting position is left on the path. Because the spare rows and columns add extra capacity, faulty blocks can be bypassed and the target can still be met.

Top module: `arm_cfg_seq`

## Requirements
- R1: While reset is held and after it releases, `test_req`, `cfg_req`, `done` and `fail` are 0 and the tip is at row 0, column 0.
- R2: A `start` pulse clears both maps and leaves a path holding only row 0, column 0. The first test request is for that position. If `target_cnt` is 0, `done` rises on the next cycle and no test is issued.
- R3: `test_req` and `cfg_req` each stay high, with the tip unchanged, until the matching acknowledge is sampled high. The request drops in the cycle after the acknowledge.
- R4: When a test is acknowledged with `test_pass`=1, the same tip is configured next. When it is acknowledged with `test_pass`=0, that block is marked faulty and is never configured.
- R5: To extend, the sequencer tries the tip's neighbours in the fixed order column+1, row+1, column-1, row-1. It takes the first neighbour that is inside the grid, is not faulty and has not been visited.
- R6: If no neighbour qualifies, or the tip block has just failed its test, the path drops its last position. The sequencer then tries to extend again from the new tip.
- R7: `done` rises in the cycle after the configure acknowledge that brings the configured count up to `target_cnt`. It then holds with both requests low until the next `start`.
- R8: `fail` rises when the path must drop a position while it holds only the starting position. It holds until the next `start`, and it is never high together with `done`.
- R9: Only one block is handled at a time. The two requests are never high together, and whenever the tip moves it moves by exactly one row or one column, or returns to row 0, column 0 on a start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle pulse that begins a run; sampled when not busy |
| target_cnt | input | $clog2(ROWS*COLS+1) | Number of blocks to configure, sampled with `start` |
| test_req | output | 1 | Asks the external tester to test the tip block |
| test_ack | input | 1 | Tester has finished; `test_pass` is valid |
| test_pass | input | 1 | 1 = tip block is healthy, 0 = tip block is defective |
| cfg_req | output | 1 | Asks the external configurator to configure the tip block |
| cfg_ack | input | 1 | Configuration of the tip block is complete |
| tip_row | output | $clog2(ROWS) | Row of the block at the arm tip |
| tip_col | output | $clog2(COLS) | Column of the block at the arm tip |
| done | output | 1 | Target count reached; held until next start |
| fail | output | 1 | Arm exhausted with target unmet; held until next start |

## Verification
The assertions check the cycle-level rules on every cycle. These are request exclusivity, requests held until acknowledged with the tip frozen, no configure request at a block the faulty map holds, single-step tip movement, and the persistence and exclusivity of `done` and `fail`. Only the bench's scenarios can show that the search order is right. To do that, the bench compares the complete sequence of tested positions, the configured count and the final outcome against a depth-first reference computed for every fault pattern of a 3x3 grid. That includes the patterns where retraction has to backtrack several levels or runs out at the start.

// File: rtl/arm_seq_pkg.sv
// Package: shared state encoding and direction stepping for the arm sequencer.
// Assumes: grids of at least 2x2; directions are tried in enum order.
package arm_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SELECT,
        ST_TEST,
        ST_CONFIG,
        ST_EXTEND,
        ST_RETRACT,
        ST_DONE,
        ST_FAIL
    } seq_state_t;

    // Enum order is the extension priority.
    typedef enum logic [1:0] {
        DIR_RIGHT,
        DIR_DOWN,
        DIR_LEFT,
        DIR_UP
    } arm_dir_t;

    // Row offset taken by one step in the given direction.
    function automatic int dir_drow(arm_dir_t d);
        case (d)
            DIR_DOWN: return 1;
            DIR_UP:   return -1;
            default:  return 0;
        endcase
    endfunction

    // Column offset taken by one step in the given direction.
    function automatic int dir_dcol(arm_dir_t d);
        case (d)
            DIR_RIGHT: return 1;
            DIR_LEFT:  return -1;
            default:   return 0;
        endcase
    endfunction

endpackage

// File: rtl/arm_cell_maps.sv
// Module: per-cell visited and faulty flags for the whole grid.
// Does:   sets one flag per cycle at cell_idx; clr wipes all flags.
// Assumes: clr has priority over marks; cell_idx < CELLS when marking.
module arm_cell_maps #(
    parameter int CELLS = 16,
    localparam int IW = $clog2(CELLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             mark_vis,
    input  logic             mark_flt,
    input  logic [IW-1:0]    cell_idx,
    output logic [CELLS-1:0] visited,
    output logic [CELLS-1:0] faulty
);

    for (genvar gi = 0; gi < CELLS; gi++) begin : g_cell
        logic vis_q;
        logic flt_q;

        // Hold this cell's two flags.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vis_q <= 1'b0;
                flt_q <= 1'b0;
            end else if (clr) begin
                vis_q <= 1'b0;
                flt_q <= 1'b0;
            end else begin
                if (mark_vis && (cell_idx == IW'(gi))) vis_q <= 1'b1;
                if (mark_flt && (cell_idx == IW'(gi))) flt_q <= 1'b1;
            end
        end

        assign visited[gi] = vis_q;
        assign faulty[gi]  = flt_q;
    end

endmodule

// File: rtl/arm_path_stack.sv
// Module: LIFO of grid positions forming the arm path.
// Does:   init leaves one entry (0,0); push appends; pop drops the last.
// Assumes: never popped at depth 1, never pushed past the cell count.
module arm_path_stack #(
    parameter int RW = 2,
    parameter int CW = 2,
    parameter int PW = 5,
    localparam int SD = 1 << PW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init,
    input  logic          push,
    input  logic          pop,
    input  logic [RW-1:0] push_row,
    input  logic [CW-1:0] push_col,
    output logic [RW-1:0] top_row,
    output logic [CW-1:0] top_col,
    output logic          at_base
);

    logic [RW-1:0] row_q [SD];
    logic [CW-1:0] col_q [SD];
    logic [PW-1:0] depth_q;

    // Track the number of positions on the path.
    always_ff @(posedge clk) begin
        if (!rst_n)      depth_q <= PW'(1);
        else if (init)   depth_q <= PW'(1);
        else if (push)   depth_q <= depth_q + PW'(1);
        else if (pop)    depth_q <= depth_q - PW'(1);
    end

    // Store the positions; the base entry is always the origin.
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            row_q[0] <= '0;
            col_q[0] <= '0;
        end else if (push) begin
            row_q[depth_q] <= push_row;
            col_q[depth_q] <= push_col;
        end
    end

    assign top_row = row_q[depth_q - PW'(1)];
    assign top_col = col_q[depth_q - PW'(1)];
    assign at_base = (depth_q == PW'(1));

endmodule

// File: rtl/arm_nbr_pick.sv
// Module: picks the first free neighbour of the tip in priority order.
// Does:   a neighbour is free when inside the grid and not blocked.
// Assumes: blocked = visited | faulty, one bit per cell, row-major.
module arm_nbr_pick
    import arm_seq_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    localparam int CELLS = ROWS * COLS,
    localparam int IW = $clog2(CELLS),
    localparam int RW = $clog2(ROWS),
    localparam int CW = $clog2(COLS)
) (
    input  logic [RW-1:0]    tip_row,
    input  logic [CW-1:0]    tip_col,
    input  logic [CELLS-1:0] blocked,
    output logic             found,
    output logic [RW-1:0]    nxt_row,
    output logic [CW-1:0]    nxt_col
);

    // Scan the four directions; the lowest-numbered free one wins.
    always_comb begin
        int   r;
        int   c;
        logic ok;
        found   = 1'b0;
        nxt_row = tip_row;
        nxt_col = tip_col;
        for (int d = 0; d < 4; d++) begin
            r  = int'(tip_row) + dir_drow(arm_dir_t'(d));
            c  = int'(tip_col) + dir_dcol(arm_dir_t'(d));
            ok = (r >= 0) && (r < ROWS) && (c >= 0) && (c < COLS);
            if (ok) ok = !blocked[IW'(r * COLS + c)];
            if (ok && !found) begin
                found   = 1'b1;
                nxt_row = RW'(r);
                nxt_col = CW'(c);
            end
        end
    end

endmodule

// File: rtl/arm_cfg_seq.sv
// Module: top-level sequencer that walks the configuration arm.
// Does:   test-then-configure at the tip, extend depth-first, retract
//         one step when blocked, finish with done or fail.
// Assumes: test_ack/cfg_ack are single-cycle responses to held requests;
//          start is ignored while a run is in progress.
module arm_cfg_seq
    import arm_seq_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    localparam int CELLS = ROWS * COLS,
    localparam int IW = $clog2(CELLS),
    localparam int PW = $clog2(CELLS + 1),
    localparam int RW = $clog2(ROWS),
    localparam int CW = $clog2(COLS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [PW-1:0] target_cnt,
    output logic          test_req,
    input  logic          test_ack,
    input  logic          test_pass,
    output logic          cfg_req,
    input  logic          cfg_ack,
    output logic [RW-1:0] tip_row,
    output logic [CW-1:0] tip_col,
    output logic          done,
    output logic          fail
);

    seq_state_t       state_q;
    seq_state_t       state_d;
    logic [PW-1:0]    goal_q;
    logic [PW-1:0]    cnt_q;
    logic [PW-1:0]    cnt_inc;
    logic             launch;
    logic             mark_vis;
    logic             mark_flt;
    logic             do_push;
    logic             do_pop;
    logic             at_base;
    logic             nbr_found;
    logic [RW-1:0]    nbr_row;
    logic [CW-1:0]    nbr_col;
    logic [IW-1:0]    tip_idx;
    logic [CELLS-1:0] vis_map;
    logic [CELLS-1:0] fault_map;

    assign launch   = start && (state_q == ST_IDLE || state_q == ST_DONE
                                || state_q == ST_FAIL);
    assign mark_vis = (state_q == ST_SELECT);
    assign mark_flt = (state_q == ST_TEST) && test_ack && !test_pass;
    assign do_push  = (state_q == ST_EXTEND) && nbr_found;
    assign do_pop   = (state_q == ST_RETRACT) && !at_base;
    assign cnt_inc  = cnt_q + PW'(1);
    assign tip_idx  = IW'(int'(tip_row) * COLS + int'(tip_col));

    arm_path_stack #(.RW(RW), .CW(CW), .PW(PW)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .init     (launch),
        .push     (do_push),
        .pop      (do_pop),
        .push_row (nbr_row),
        .push_col (nbr_col),
        .top_row  (tip_row),
        .top_col  (tip_col),
        .at_base  (at_base)
    );

    arm_cell_maps #(.CELLS(CELLS)) u_maps (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (launch),
        .mark_vis (mark_vis),
        .mark_flt (mark_flt),
        .cell_idx (tip_idx),
        .visited  (vis_map),
        .faulty   (fault_map)
    );

    arm_nbr_pick #(.ROWS(ROWS), .COLS(COLS)) u_pick (
        .tip_row (tip_row),
        .tip_col (tip_col),
        .blocked (vis_map | fault_map),
        .found   (nbr_found),
        .nxt_row (nbr_row),
        .nxt_col (nbr_col)
    );

    // Next-state decision for the arm walk.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE, ST_DONE, ST_FAIL: begin
                if (start) state_d = (target_cnt == '0) ? ST_DONE : ST_SELECT;
            end
            ST_SELECT:  state_d = ST_TEST;
            ST_TEST: begin
                if (test_ack) state_d = test_pass ? ST_CONFIG : ST_RETRACT;
            end
            ST_CONFIG: begin
                if (cfg_ack) state_d = (cnt_inc == goal_q) ? ST_DONE : ST_EXTEND;
            end
            ST_EXTEND:  state_d = nbr_found ? ST_SELECT : ST_RETRACT;
            ST_RETRACT: state_d = at_base ? ST_FAIL : ST_EXTEND;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture the goal and count configured blocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            goal_q <= '0;
            cnt_q  <= '0;
        end else if (launch) begin
            goal_q <= target_cnt;
            cnt_q  <= '0;
        end else if (state_q == ST_CONFIG && cfg_ack) begin
            cnt_q  <= cnt_inc;
        end
    end

    assign test_req = (state_q == ST_TEST);
    assign cfg_req  = (state_q == ST_CONFIG);
    assign done     = (state_q == ST_DONE);
    assign fail     = (state_q == ST_FAIL);

endmodule

// File: rtl/arm_cfg_seq_chk.sv
// Module: protocol and movement checker bound into arm_cfg_seq.
// Does:   watches handshakes, tip motion and end states every cycle.
// Assumes: faulty is the sequencer's own faulty map, tip_idx its tip cell.
module arm_cfg_seq_chk #(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    localparam int CELLS = ROWS * COLS,
    localparam int IW = $clog2(CELLS),
    localparam int RW = $clog2(ROWS),
    localparam int CW = $clog2(COLS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             test_req,
    input logic             test_ack,
    input logic             cfg_req,
    input logic             cfg_ack,
    input logic [RW-1:0]    tip_row,
    input logic [CW-1:0]    tip_col,
    input logic             done,
    input logic             fail,
    input logic [IW-1:0]    tip_idx,
    input logic [CELLS-1:0] faulty
);

    logic [RW-1:0] prev_row;
    logic [CW-1:0] prev_col;
    logic          moved;
    logic          one_step;
    int            dr;
    int            dc;

    // Remember the tip of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_row <= '0;
            prev_col <= '0;
        end else begin
            prev_row <= tip_row;
            prev_col <= tip_col;
        end
    end

    // Distance between the current and previous tip.
    always_comb begin
        dr       = int'(tip_row) - int'(prev_row);
        dc       = int'(tip_col) - int'(prev_col);
        moved    = (tip_row != prev_row) || (tip_col != prev_col);
        one_step = ((dr == 1 || dr == -1) && dc == 0) ||
                   ((dc == 1 || dc == -1) && dr == 0);
    end

    AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(test_req && cfg_req)); // R9
    AST_TIP_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        moved |-> (one_step || (tip_row == '0 && tip_col == '0))); // R9
    AST_TEST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (test_req && !test_ack) |=> test_req); // R3
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !cfg_ack) |=> cfg_req); // R3
    AST_TIP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((test_req && !test_ack) || (cfg_req && !cfg_ack)) |=>
        $stable({tip_row, tip_col})); // R3
    AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        ((test_req && test_ack) || (cfg_req && cfg_ack)) |=>
        !$stable({test_req, cfg_req})); // R3
    AST_NO_CFG_FAULTY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> !faulty[tip_idx]); // R4
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done); // R7
    AST_END_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fail) |-> (!test_req && !cfg_req)); // R7
    AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start) |=> fail); // R8
    AST_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail)); // R8

endmodule

bind arm_cfg_seq arm_cfg_seq_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .test_req (test_req),
    .test_ack (test_ack),
    .cfg_req  (cfg_req),
    .cfg_ack  (cfg_ack),
    .tip_row  (tip_row),
    .tip_col  (tip_col),
    .done     (done),
    .fail     (fail),
    .tip_idx  (tip_idx),
    .faulty   (fault_map)
);

// File: tb/arm_cfg_seq_tb_top.sv
// Bench: sweeps every fault pattern of a 3x3 grid and compares the tested
// sequence, configure count and outcome with a depth-first reference.
module arm_cfg_seq_tb_top;

    localparam int ROWS  = 3;
    localparam int COLS  = 3;
    localparam int CELLS = ROWS * COLS;
    localparam int PW    = $clog2(CELLS + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [PW-1:0] target_cnt = '0;
    logic          test_req;
    logic          test_ack = 1'b0;
    logic          test_pass = 1'b0;
    logic          cfg_req;
    logic          cfg_ack = 1'b0;
    logic [1:0]    tip_row;
    logic [1:0]    tip_col;
    logic          done;
    logic          fail;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    int exp_seq [64];
    int exp_len;
    int exp_cfg;
    bit exp_done;

    arm_cfg_seq #(.ROWS(ROWS), .COLS(COLS)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .target_cnt (target_cnt),
        .test_req   (test_req),
        .test_ack   (test_ack),
        .test_pass  (test_pass),
        .cfg_req    (cfg_req),
        .cfg_ack    (cfg_ack),
        .tip_row    (tip_row),
        .tip_col    (tip_col),
        .done       (done),
        .fail       (fail)
    );

    always #2 clk = ~clk;

    // Record one check and report a mismatch.
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Depth-first reference walk over a fault pattern.
    task automatic model(input logic [CELLS-1:0] flt, input int tgt);
        int stk [CELLS];
        int sp, cnt, tip, r, c, nr, nc;
        bit vis [CELLS];
        bit back, found, fin;
        exp_len = 0; exp_cfg = 0; exp_done = 0;
        if (tgt == 0) begin exp_done = 1; return; end
        for (int i = 0; i < CELLS; i++) vis[i] = 0;
        stk[0] = 0; sp = 1; cnt = 0; fin = 0;
        while (!fin) begin
            tip = stk[sp-1];
            exp_seq[exp_len] = tip; exp_len++;
            vis[tip] = 1;
            back = 0;
            if (flt[tip]) back = 1;
            else begin
                cnt++;
                if (cnt == tgt) begin exp_done = 1; fin = 1; end
            end
            found = 0;
            while (!fin && !found) begin
                if (back) begin
                    if (sp == 1) fin = 1;
                    else begin sp--; back = 0; end
                end else begin
                    r = stk[sp-1] / COLS; c = stk[sp-1] % COLS;
                    for (int d = 0; d < 4; d++) begin
                        nr = r + ((d == 1) ? 1 : (d == 3) ? -1 : 0);
                        nc = c + ((d == 0) ? 1 : (d == 2) ? -1 : 0);
                        if (!found && nr >= 0 && nr < ROWS && nc >= 0 && nc < COLS
                            && !vis[nr*COLS+nc]) begin
                            found = 1; stk[sp] = nr*COLS + nc; sp++;
                        end
                    end
                    if (!found) back = 1;
                end
            end
        end
        exp_cfg = cnt;
    endtask

    // Run one case and act as tester and configurator.
    task automatic run_case(input logic [CELLS-1:0] flt, input int tgt);
        int k, ncfg, guard, idx, last;
        model(flt, tgt);
        k = 0; ncfg = 0; guard = 0; last = -1;
        @(negedge clk);
        target_cnt = PW'(tgt); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!(done || fail) && guard < 3000) begin
            idx = int'(tip_row) * COLS + int'(tip_col);
            if (test_req) begin
                if (k == 0) chk(idx == 0, "R2 first test at origin", idx, 0);
                if (k < exp_len) chk(idx == exp_seq[k], "R5 R6 tested position order", idx, exp_seq[k]);
                else chk(0, "R6 extra test", k, exp_len);
                k++; last = idx;
                repeat ((k + tgt) % 3) @(negedge clk);
                test_ack = 1'b1; test_pass = !flt[idx];
                @(negedge clk);
                test_ack = 1'b0; test_pass = 1'b0;
                guard += 4;
            end else if (cfg_req) begin
                chk(!flt[idx], "R4 faulty block configured", idx, -1);
                chk(idx == last, "R4 configure the tested tip", idx, last);
                ncfg++;
                repeat ((ncfg + 1) % 3) @(negedge clk);
                cfg_ack = 1'b1;
                @(negedge clk);
                cfg_ack = 1'b0;
                guard += 4;
            end else begin
                @(negedge clk);
                guard++;
            end
        end
        chk(done == exp_done, "R7 done outcome", done, exp_done);
        chk(fail == !exp_done, "R8 fail outcome", fail, !exp_done);
        chk(k == exp_len, "R5 number of tests", k, exp_len);
        chk(ncfg == exp_cfg, "R7 configured count", ncfg, exp_cfg);
        @(negedge clk);
        chk(done == exp_done && fail == !exp_done && !test_req && !cfg_req,
            "R7 R8 end state held", {done, fail}, {exp_done, !exp_done});
    endtask

    // Cycle watchdog.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog expired actual=%0d expected=<190000", cycles);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    // Main stimulus.
    initial begin
        repeat (3) @(negedge clk);
        chk(!test_req && !cfg_req && !done && !fail && tip_row == 0 && tip_col == 0,
            "R1 state under reset", {test_req, cfg_req, done, fail}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!test_req && !cfg_req && !done && !fail && tip_row == 0 && tip_col == 0,
            "R1 idle after reset", {test_req, cfg_req, done, fail}, 0);
        // R2: zero target finishes without any test
        run_case('0, 0);
        // Full grid snake, unreachable target, dead origin
        run_case('0, 9);
        run_case('0, 10);
        run_case(9'b000000001, 5);
        // Exhaustive sweep of fault patterns with varied targets
        for (int p = 0; p < (1 << CELLS); p++) begin
            run_case(p[CELLS-1:0], (p * 7) % 11);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule